// File: doc/BRIEF.md
# Write-Only I2C Register Receiver

This block is a target on a two-wire I2C bus that only ever accepts writes. The system clock oversamples the serial clock and data lines, and the block detects START and STOP conditions. It checks the first byte against its own 7-bit address and then takes a register pointer byte followed by any number of data bytes. For each data byte it emits a single-cycle write strobe that carries the pointer and the byte, and then the pointer moves to the next register. It acknowledges by raising an output enable that pulls the data line low during the ninth clock of each byte it accepts.

The upper five bits of the address come from a parameter. The two lowest bits come from a 2-bit strap code that tells the block how its address pin is wired. A read request, or a byte addressed to some other target, gets no acknowledge, and the block then stays silent until the next START. The system clock is assumed to run at least ten times faster than the serial clock.

Top module: `i2cw_target`

## Requirements
- R1: The block's address is {ADDR_HI, low}, with ADDR_HI defaulting to 11000. `low` is set by strap_i as follows: code 0 (pin grounded) gives 00, code 1 (pin at supply) gives 11, code 2 (pin tied to the clock line) gives 01, and code 3 (pin tied to the data line) gives 10. A first byte equal to {address, 0}, sent MSB first, is acknowledged.
- R2: A first byte whose seven address bits differ from the block's address, or whose last bit is 1 (read), gets no acknowledge. It also gets no acknowledge for any later byte, and it produces no strobe, until the next START.
- R3: The byte after an acknowledged address byte is taken as the register pointer. It is acknowledged and produces no strobe.
- R4: Each later byte (bits sampled while SCL is high, MSB first) is acknowledged and produces exactly one one-cycle wr_valid_o pulse. That pulse carries wr_addr_o equal to the current pointer and wr_data_o equal to the byte.
- R5: The pointer increases by one after every data byte, wrapping from 255 to 0. Consecutive strobes within one transfer therefore carry consecutive addresses.
- R6: A STOP returns the block to idle, so bytes clocked afterwards without a START are ignored. A repeated START at any point restarts the address phase.
- R7: While reset is asserted, and in the cycle after it, sda_oe_o and wr_valid_o are 0.
- R8: sda_oe_o changes only while the synchronized SCL is low, so it is steady throughout every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| strap_i | input | 2 | Address pin wiring code (0 ground, 1 supply, 2 clock line, 3 data line) |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| wr_valid_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register address of the strobe |
| wr_data_o | output | 8 | Data byte of the strobe |

## Verification
The bound checker checks on every cycle that the acknowledge enable moves only while the synchronized clock is low, that each strobe lasts one cycle and coincides with an acknowledge, that strobes since the last START step their address by one, and that reset leaves both outputs quiet. Address decoding for every strap code, every pair of low address bits and both transfer directions can only be shown by the bench's sweep. The same holds for the silence after a rejected address, pointer wrap across a long burst, ignored bytes after STOP and the restart on a repeated START.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
    localparam int DEV_W     = 7;
    localparam int HI_W      = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_REG,
        ST_DATA,
        ST_SKIP
    } rx_state_e;

    typedef enum logic [1:0] {
        STRAP_GND  = 2'd0,
        STRAP_VCC  = 2'd1,
        STRAP_SCLK = 2'd2,
        STRAP_SDAT = 2'd3
    } strap_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [1:0] strap_low_bits(input logic [1:0] code);
        logic [1:0] low;
        case (strap_e'(code))
            STRAP_GND:  low = 2'b00;
            STRAP_VCC:  low = 2'b11;
            STRAP_SCLK: low = 2'b01;
            default:    low = 2'b10;
        endcase
        return low;
    endfunction

    function automatic logic [DEV_W-1:0] own_address(input logic [HI_W-1:0] hi,
                                                     input logic [1:0] code);
        return {hi, strap_low_bits(code)};
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond
    import i2cw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/i2cw_addr_match.sv
module i2cw_addr_match
    import i2cw_pkg::*;
#(
    parameter logic [HI_W-1:0] ADDR_HI = 5'b11000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] first_byte,
    output logic              hit
);

    logic [DEV_W-1:0] own_q;

    always_ff @(posedge clk) begin
        if (rst) own_q <= own_address(ADDR_HI, 2'd0);
        else     own_q <= own_address(ADDR_HI, strap);
    end

    assign hit = (first_byte[BYTE_W-1:1] == own_q) && (first_byte[0] == 1'b0);

endmodule

// File: rtl/i2cw_rx.sv
module i2cw_rx
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              addr_hit,
    output logic [BYTE_W-1:0] shift_q,
    output logic              oe_q,
    output wr_req_t           wr_q
);

    localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);

    rx_state_e            state_q;
    logic                 acking_q;
    logic [BIT_CNT_W-1:0] bits_q;
    logic [BYTE_W-1:0]    ptr_q;
    logic                 listening;

    assign listening = (state_q != ST_IDLE) && (state_q != ST_SKIP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            acking_q <= 1'b0;
            bits_q   <= '0;
            shift_q  <= '0;
            ptr_q    <= '0;
            oe_q     <= 1'b0;
            wr_q     <= '0;
        end else begin
            wr_q.valid <= 1'b0;
            if (evt.start) begin
                state_q  <= ST_DEV;
                acking_q <= 1'b0;
                bits_q   <= '0;
                oe_q     <= 1'b0;
            end else if (evt.stop) begin
                state_q  <= ST_IDLE;
                acking_q <= 1'b0;
                bits_q   <= '0;
                oe_q     <= 1'b0;
            end else if (listening) begin
                if (evt.scl_rise && !acking_q && bits_q != FULL) begin
                    shift_q <= {shift_q[BYTE_W-2:0], evt.sda};
                    bits_q  <= bits_q + 1'b1;
                end else if (evt.scl_fall) begin
                    if (acking_q) begin
                        acking_q <= 1'b0;
                        oe_q     <= 1'b0;
                        bits_q   <= '0;
                    end else if (bits_q == FULL) begin
                        case (state_q)
                            ST_DEV: begin
                                if (addr_hit) begin
                                    acking_q <= 1'b1;
                                    oe_q     <= 1'b1;
                                    state_q  <= ST_REG;
                                end else begin
                                    state_q  <= ST_SKIP;
                                end
                            end
                            ST_REG: begin
                                acking_q <= 1'b1;
                                oe_q     <= 1'b1;
                                ptr_q    <= shift_q;
                                state_q  <= ST_DATA;
                            end
                            ST_DATA: begin
                                acking_q   <= 1'b1;
                                oe_q       <= 1'b1;
                                wr_q.valid <= 1'b1;
                                wr_q.addr  <= ptr_q;
                                wr_q.data  <= shift_q;
                                ptr_q      <= ptr_q + 1'b1;
                            end
                            default: state_q <= ST_IDLE;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2cw_target.sv
module i2cw_target
    import i2cw_pkg::*;
#(
    parameter logic [HI_W-1:0] ADDR_HI     = 5'b11000,
    parameter int              SYNC_STAGES = 2,
    parameter int              REG_W       = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       strap_i,
    output logic             sda_oe_o,
    output logic             wr_valid_o,
    output logic [REG_W-1:0] wr_addr_o,
    output logic [REG_W-1:0] wr_data_o
);

    logic [1:0]        line_s;
    logic              scl_s;
    logic              sda_s;
    logic              start_det;
    bus_evt_t          evt;
    logic [BYTE_W-1:0] shift_q;
    logic              addr_hit;
    wr_req_t           wr_q;

    i2cw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2cw_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt   (evt)
    );

    assign start_det = evt.start;

    i2cw_addr_match #(.ADDR_HI(ADDR_HI)) u_match (
        .clk        (clk),
        .rst        (rst),
        .strap      (strap_i),
        .first_byte (shift_q),
        .hit        (addr_hit)
    );

    i2cw_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_hit (addr_hit),
        .shift_q  (shift_q),
        .oe_q     (sda_oe_o),
        .wr_q     (wr_q)
    );

    assign wr_valid_o = wr_q.valid;
    assign wr_addr_o  = REG_W'(wr_q.addr);
    assign wr_data_o  = REG_W'(wr_q.data);

endmodule

// File: rtl/i2cw_target_chk.sv
module i2cw_target_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_s,
    input logic             start_det,
    input logic             sda_oe_o,
    input logic             wr_valid_o,
    input logic [REG_W-1:0] wr_addr_o
);

    logic             chain_q;
    logic [REG_W-1:0] next_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q     <= 1'b0;
            next_addr_q <= '0;
        end else if (start_det) begin
            chain_q <= 1'b0;
        end else if (wr_valid_o) begin
            chain_q     <= 1'b1;
            next_addr_q <= wr_addr_o + 1'b1;
        end
    end

    p_quiet_after_reset_r7: assert property (@(posedge clk)
        rst |=> (!sda_oe_o && !wr_valid_o));

    p_oe_rise_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_s);

    p_oe_fall_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe_o) |-> !scl_s);

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |=> !wr_valid_o);

    p_strobe_acked_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> sda_oe_o);

    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && chain_q) |-> (wr_addr_o == next_addr_q));

endmodule

bind i2cw_target i2cw_target_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (scl_s),
    .start_det  (start_det),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o)
);

// File: tb/i2cw_target_test.sv
`timescale 1ns/1ps
module i2cw_target_test;

    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'd0;
    logic       sda_line;
    logic       sda_oe_o;
    logic       wr_valid_o;
    logic [7:0] wr_addr_o;
    logic [7:0] wr_data_o;

    int checks = 0;
    int fails  = 0;
    int cap_total = 0;
    logic [7:0] cap_addr [64];
    logic [7:0] cap_data [64];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe_o;

    i2cw_target uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_oe_o   (sda_oe_o),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o)
    );

    always @(negedge clk) begin
        if (wr_valid_o) begin
            cap_addr[cap_total % 64] = wr_addr_o;
            cap_data[cap_total % 64] = wr_data_o;
            cap_total = cap_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic oe_a;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        oe_a = sda_oe_o;
        ack  = ~sda_line;
        wq();
        chk(sda_oe_o == oe_a, "R8 oe steady in SCL high", int'(sda_oe_o), int'(oe_a));
        scl_m = 1'b0; wq();
    endtask

    function automatic logic [1:0] exp_low(input int code);
        case (code)
            0: return 2'b00;
            1: return 2'b11;
            2: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic ack;
        int   base;
        int   it;
        logic [7:0] rg;
        logic [7:0] dt;
        repeat (5) @(negedge clk);
        chk(sda_oe_o == 1'b0, "R7 oe in reset", int'(sda_oe_o), 0);
        chk(wr_valid_o == 1'b0, "R7 valid in reset", int'(wr_valid_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sda_oe_o == 1'b0 && wr_valid_o == 1'b0, "R7 quiet after reset",
            int'({sda_oe_o, wr_valid_o}), 0);
        wq();

        // R1 R2 R3 R4: sweep strap code x low address bits x direction
        it = 0;
        for (int code = 0; code < 4; code++) begin
            strap = 2'(code);
            wq();
            for (int lo = 0; lo < 4; lo++) begin
                for (int rw = 0; rw < 2; rw++) begin
                    bit hit;
                    hit  = (2'(lo) == exp_low(code)) && (rw == 0);
                    rg   = 8'(8'h30 + it);
                    dt   = 8'(it * 29 + 7);
                    base = cap_total;
                    bus_start();
                    send_byte({5'b11000, 2'(lo), 1'(rw)}, ack);
                    chk(ack == hit, hit ? "R1 address ack" : "R2 reject ack",
                        int'(ack), int'(hit));
                    send_byte(rg, ack);
                    chk(ack == hit, hit ? "R3 pointer ack" : "R2 silent pointer",
                        int'(ack), int'(hit));
                    chk(cap_total == base, "R3 no strobe on pointer", cap_total - base, 0);
                    send_byte(dt, ack);
                    chk(ack == hit, hit ? "R4 data ack" : "R2 silent data",
                        int'(ack), int'(hit));
                    chk(cap_total - base == (hit ? 1 : 0), hit ? "R4 strobe count" : "R2 no strobe",
                        cap_total - base, hit ? 1 : 0);
                    if (hit && cap_total > base) begin
                        chk(cap_addr[base % 64] == rg, "R4 strobe address",
                            int'(cap_addr[base % 64]), int'(rg));
                        chk(cap_data[base % 64] == dt, "R4 strobe data",
                            int'(cap_data[base % 64]), int'(dt));
                    end
                    bus_stop();
                    it++;
                end
            end
        end

        // R1: wrong upper bits rejected even with correct low bits
        strap = 2'd2;
        wq();
        base = cap_total;
        bus_start();
        send_byte({5'b10000, 2'b01, 1'b0}, ack);
        chk(ack == 1'b0, "R1 upper bits mismatch", int'(ack), 0);
        send_byte(8'h11, ack);
        chk(ack == 1'b0 && cap_total == base, "R2 silent after mismatch",
            int'(ack) + cap_total - base, 0);
        bus_stop();

        // R5: burst with pointer wrap
        strap = 2'd0;
        wq();
        base = cap_total;
        bus_start();
        send_byte({5'b11000, 2'b00, 1'b0}, ack);
        send_byte(8'hFD, ack);
        for (int k = 0; k < 5; k++) begin
            send_byte(8'(k * 37 + 5), ack);
            chk(ack == 1'b1, "R5 burst ack", int'(ack), 1);
        end
        bus_stop();
        chk(cap_total - base == 5, "R5 burst count", cap_total - base, 5);
        for (int k = 0; k < 5; k++) begin
            chk(cap_addr[(base + k) % 64] == 8'(8'hFD + k), "R5 pointer step",
                int'(cap_addr[(base + k) % 64]), int'(8'(8'hFD + k)));
            chk(cap_data[(base + k) % 64] == 8'(k * 37 + 5), "R4 burst data",
                int'(cap_data[(base + k) % 64]), int'(8'(k * 37 + 5)));
        end

        // R6: bytes after STOP without START are ignored
        base = cap_total;
        send_byte({5'b11000, 2'b00, 1'b0}, ack);
        chk(ack == 1'b0, "R6 no ack after stop", int'(ack), 0);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        chk(ack == 1'b0 && cap_total == base, "R6 ignored after stop",
            int'(ack) + cap_total - base, 0);
        bus_stop();

        // R6: repeated START restarts the address phase
        base = cap_total;
        bus_start();
        send_byte({5'b11000, 2'b00, 1'b0}, ack);
        send_byte(8'h10, ack);
        send_byte(8'hA5, ack);
        bus_start();
        send_byte({5'b11000, 2'b00, 1'b0}, ack);
        chk(ack == 1'b1, "R6 repeated start ack", int'(ack), 1);
        send_byte(8'h40, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        chk(cap_total - base == 2, "R6 repeated start count", cap_total - base, 2);
        chk(cap_addr[(base + 1) % 64] == 8'h40, "R6 new pointer",
            int'(cap_addr[(base + 1) % 64]), 8'h40);
        chk(cap_data[(base + 1) % 64] == 8'h5A, "R6 new data",
            int'(cap_data[(base + 1) % 64]), 8'h5A);

        wq();
        finish_run();
    end

endmodule